// File: doc/BRIEF.md
# Packet-Count Interrupt and DMA Request Controller

This block decides when a host should be told that captured video-data packets are waiting in the packet store, and it paces DMA transfers out of that store. It watches how many complete packets are currently buffered. When that number climbs to a programmed threshold, it raises an interrupt. The trigger can be limited to a chosen video line number, so the host is woken once per frame at a predictable point. A source can also disable itself on firing, so a slow host is not interrupted again until it re-arms the source.

Transfers are driven one byte at a time with a request/acknowledge handshake. A packet is 44 bytes. In demand mode the request follows the buffer: it is raised whenever a whole packet, or the rest of a partly read one, is waiting. In burst mode the host starts a run of a programmed number of packets, and the request stops when the run is done. A second interrupt source reports the end of the run, and it can also disable itself on firing.

Top module: `pktirq_dma_ctrl`

## Requirements
- R1: After a synchronous reset, `irq`, `dmarq`, `burst_active`, both `irq_pend` bits and both `irq_en` bits are 0. Bit 0 of each 2-bit source vector is the packet-count source and bit 1 is the burst-done source.
- R2: With `thr_level` nonzero and line gating off, the packet-count condition is `pkt_avail >= thr_level`. On the clock edge where this condition first becomes true, if `irq_en[0]` is set, `irq_pend[0]` becomes 1 on that edge.
- R3: With `line_gate_en` set, the packet-count condition also requires `line_num == line_target`. The source fires only on an edge where this combined condition first becomes true.
- R4: A source event that arrives while its `irq_en` bit is 0 leaves that source's `irq_pend` bit at 0.
- R5: When a source fires and its `auto_mask` bit is 1, its `irq_en` bit clears on the same edge, unless `en_set` for that bit is asserted in that cycle. When `auto_mask` is 0, the enable stays set. `en_clr` overrides `en_set`.
- R6: Pending bits are sticky. A 1 in `sts_clr` clears the matching bit on the next edge, but a new event on the same edge keeps the bit set.
- R7: `irq` is 1 exactly when at least one `irq_pend` bit is 1.
- R8: `dma_mode` encodes 0 as off, 1 as burst, 2 as demand and 3 as off. In an off mode, `dmarq` is 0 on the following edge.
- R9: A byte is transferred on an edge where both `dmack` and `rd_strobe` are 1. `dmarq` is 0 on the edge after any cycle with `dmack` high, and it is raised again one edge after `dmack` falls if more bytes are wanted.
- R10: In demand mode, `dmarq` is requested while `pkt_avail` is nonzero or a packet is partly transferred. It stays low once the last byte of the last available packet has been moved.
- R11: In burst mode, a `dma_start` pulse while idle with a nonzero `burst_len` sets `burst_active`. After `burst_len` × 44 transferred bytes, `burst_active` falls and `dmarq` stays low even though more packets are waiting.
- R12: The burst-done source fires on the edge where `burst_active` falls at the end of a run. It obeys R4, R5 and R6 like the packet-count source.
- R13: A `thr_level` of 0 disables the packet-count trigger entirely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pkt_avail | input | CNT_W | Complete packets waiting in the buffer |
| line_num | input | LINE_W | Current video line number |
| rd_strobe | input | 1 | Byte read strobe from the data port |
| dmack | input | 1 | DMA acknowledge |
| thr_level | input | CNT_W | Packet threshold for the count interrupt, 0 disables |
| line_gate_en | input | 1 | Restrict the count interrupt to one line |
| line_target | input | LINE_W | Line number used when gating |
| auto_mask | input | 2 | Self-masking select per source |
| en_set | input | 2 | Pulse to set source enables |
| en_clr | input | 2 | Pulse to clear source enables |
| sts_clr | input | 2 | Write-1-to-clear for pending bits |
| dma_mode | input | 2 | DMA mode: 0 off, 1 burst, 2 demand, 3 off |
| burst_len | input | CNT_W | Packets per burst run |
| dma_start | input | 1 | Start a burst run |
| irq | output | 1 | Interrupt request |
| dmarq | output | 1 | DMA request |
| irq_en | output | 2 | Current source enables |
| irq_pend | output | 2 | Pending source status |
| burst_active | output | 1 | Burst run in progress |

## Verification
Suppose the packet-count edge detector held stale history. A threshold crossing would then fail to set `irq_pend[0]` on the very edge the count arrives, or a gated line would fire on the wrong line. The sweep over thresholds and line numbers exposes either fault within one cycle. If the byte or packet counters drifted, a burst would end early or run past its length. That shows as `burst_active` falling at the wrong byte, or as `dmarq` rising again while a surplus packet waits. Both are visible within a few cycles of the 44th byte of the final packet. A broken handshake shows on the very next edge: `dmarq` fails to drop after `dmack`, or fails to return once `dmack` is released.

// File: rtl/pktirq_pkg.sv
package pktirq_pkg;

    typedef enum logic [1:0] {
        DMA_OFF     = 2'd0,
        DMA_BURST   = 2'd1,
        DMA_DEMAND  = 2'd2,
        DMA_OFF_ALT = 2'd3
    } dma_mode_e;

    localparam int SRC_COUNT = 0;
    localparam int SRC_DONE  = 1;
    localparam int NUM_SRC   = 2;

    typedef struct packed {
        logic en;
        logic pend;
    } src_state_t;

    function automatic logic mode_is_burst(input dma_mode_e m);
        return m == DMA_BURST;
    endfunction

    function automatic logic mode_is_demand(input dma_mode_e m);
        return m == DMA_DEMAND;
    endfunction

endpackage

// File: rtl/pktirq_trig.sv
module pktirq_trig #(
    parameter int CNT_W  = 6,
    parameter int LINE_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  pkt_avail,
    input  logic [CNT_W-1:0]  thr_level,
    input  logic              line_gate_en,
    input  logic [LINE_W-1:0] line_num,
    input  logic [LINE_W-1:0] line_target,
    output logic              evt
);
    logic level_ok;
    logic line_ok;
    logic cond_now;
    logic cond_q;

    assign level_ok = (thr_level != '0) && (pkt_avail >= thr_level);
    assign line_ok  = !line_gate_en || (line_num == line_target);
    assign cond_now = level_ok && line_ok;
    assign evt      = cond_now && !cond_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cond_q <= 1'b0;
        end else begin
            cond_q <= cond_now;
        end
    end
endmodule

// File: rtl/pktirq_src.sv
module pktirq_src
    import pktirq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       evt,
    input  logic       auto_mask,
    input  logic       en_set,
    input  logic       en_clr,
    input  logic       sts_clr,
    output src_state_t st
);
    src_state_t st_n;
    logic       fire;

    assign fire = evt && st.en;

    always_comb begin
        st_n.pend = (st.pend && !sts_clr) || fire;
        st_n.en   = st.en;
        if (fire && auto_mask) st_n.en = 1'b0;
        if (en_set)            st_n.en = 1'b1;
        if (en_clr)            st_n.en = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            st <= st_n;
        end
    end
endmodule

// File: rtl/pktirq_dma.sv
module pktirq_dma
    import pktirq_pkg::*;
#(
    parameter int CNT_W     = 6,
    parameter int PKT_BYTES = 44
) (
    input  logic             clk,
    input  logic             rst,
    input  dma_mode_e        mode,
    input  logic [CNT_W-1:0] pkt_avail,
    input  logic [CNT_W-1:0] burst_len,
    input  logic             dma_start,
    input  logic             dmack,
    input  logic             rd_strobe,
    output logic             dmarq,
    output logic             burst_active,
    output logic             done_evt
);
    localparam int BYTE_W = (PKT_BYTES > 1) ? $clog2(PKT_BYTES) : 1;
    localparam logic [BYTE_W-1:0] LAST_BYTE = BYTE_W'(PKT_BYTES - 1);
    localparam logic [CNT_W-1:0]  ONE_PKT   = CNT_W'(1);

    logic [BYTE_W-1:0] byte_cnt;
    logic [CNT_W-1:0]  left;
    logic              is_burst;
    logic              is_demand;
    logic              xfer;
    logic              pkt_end;
    logic              data_ready;
    logic              want;

    assign is_burst   = mode_is_burst(mode);
    assign is_demand  = mode_is_demand(mode);
    assign xfer       = dmack && rd_strobe && (is_demand || (is_burst && burst_active));
    assign pkt_end    = xfer && (byte_cnt == LAST_BYTE);
    assign data_ready = (byte_cnt != '0) || (pkt_avail != '0);
    assign want       = data_ready && (is_demand || (is_burst && burst_active));
    assign done_evt   = pkt_end && is_burst && (left == ONE_PKT);

    always_ff @(posedge clk) begin
        if (rst) begin
            byte_cnt <= '0;
        end else if (!is_burst && !is_demand) begin
            byte_cnt <= '0;
        end else if (xfer) begin
            byte_cnt <= pkt_end ? '0 : byte_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            burst_active <= 1'b0;
            left         <= '0;
        end else if (!is_burst) begin
            burst_active <= 1'b0;
            left         <= '0;
        end else if (!burst_active) begin
            if (dma_start && (burst_len != '0)) begin
                burst_active <= 1'b1;
                left         <= burst_len;
            end
        end else if (pkt_end) begin
            left <= left - 1'b1;
            if (left == ONE_PKT) burst_active <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dmarq <= 1'b0;
        end else begin
            dmarq <= want && !dmack;
        end
    end
endmodule

// File: rtl/pktirq_dma_ctrl.sv
module pktirq_dma_ctrl
    import pktirq_pkg::*;
#(
    parameter int CNT_W     = 6,
    parameter int LINE_W    = 9,
    parameter int PKT_BYTES = 44
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  pkt_avail,
    input  logic [LINE_W-1:0] line_num,
    input  logic              rd_strobe,
    input  logic              dmack,
    input  logic [CNT_W-1:0]  thr_level,
    input  logic              line_gate_en,
    input  logic [LINE_W-1:0] line_target,
    input  logic [1:0]        auto_mask,
    input  logic [1:0]        en_set,
    input  logic [1:0]        en_clr,
    input  logic [1:0]        sts_clr,
    input  logic [1:0]        dma_mode,
    input  logic [CNT_W-1:0]  burst_len,
    input  logic              dma_start,
    output logic              irq,
    output logic              dmarq,
    output logic [1:0]        irq_en,
    output logic [1:0]        irq_pend,
    output logic              burst_active
);
    logic [NUM_SRC-1:0] src_evt;
    src_state_t         src_st [NUM_SRC];
    logic               count_evt;
    logic               done_evt;
    dma_mode_e          mode;

    assign mode = dma_mode_e'(dma_mode);

    pktirq_trig #(.CNT_W(CNT_W), .LINE_W(LINE_W)) u_trig (
        .clk          (clk),
        .rst          (rst),
        .pkt_avail    (pkt_avail),
        .thr_level    (thr_level),
        .line_gate_en (line_gate_en),
        .line_num     (line_num),
        .line_target  (line_target),
        .evt          (count_evt)
    );

    pktirq_dma #(.CNT_W(CNT_W), .PKT_BYTES(PKT_BYTES)) u_dma (
        .clk          (clk),
        .rst          (rst),
        .mode         (mode),
        .pkt_avail    (pkt_avail),
        .burst_len    (burst_len),
        .dma_start    (dma_start),
        .dmack        (dmack),
        .rd_strobe    (rd_strobe),
        .dmarq        (dmarq),
        .burst_active (burst_active),
        .done_evt     (done_evt)
    );

    assign src_evt[SRC_COUNT] = count_evt;
    assign src_evt[SRC_DONE]  = done_evt;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        pktirq_src u_src (
            .clk       (clk),
            .rst       (rst),
            .evt       (src_evt[i]),
            .auto_mask (auto_mask[i]),
            .en_set    (en_set[i]),
            .en_clr    (en_clr[i]),
            .sts_clr   (sts_clr[i]),
            .st        (src_st[i])
        );
        assign irq_en[i]   = src_st[i].en;
        assign irq_pend[i] = src_st[i].pend;
    end

    assign irq = |irq_pend;
endmodule

// File: rtl/pktirq_dma_ctrl_chk.sv
module pktirq_dma_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       dmack,
    input logic [1:0] dma_mode,
    input logic [1:0] auto_mask,
    input logic [1:0] en_set,
    input logic       dmarq,
    input logic [1:0] irq_en,
    input logic [1:0] irq_pend,
    input logic       burst_active
);
    assert_count_needs_en_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_pend[0]) |-> $past(irq_en[0]));

    assert_done_needs_en_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_pend[1]) |-> $past(irq_en[1]));

    assert_self_mask_R5: assert property (@(posedge clk) disable iff (rst)
        ($rose(irq_pend[0]) && $past(auto_mask[0]) && !$past(en_set[0])) |-> !irq_en[0]);

    assert_ack_drops_req_R9: assert property (@(posedge clk) disable iff (rst)
        dmack |=> !dmarq);

    assert_off_mode_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        (dma_mode == 2'd0 || dma_mode == 2'd3) |=> !dmarq);

    assert_burst_done_irq_R12: assert property (@(posedge clk) disable iff (rst)
        ($fell(burst_active) && $past(dma_mode) == 2'd1 && $past(irq_en[1])) |-> irq_pend[1]);
endmodule

bind pktirq_dma_ctrl pktirq_dma_ctrl_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .dmack        (dmack),
    .dma_mode     (dma_mode),
    .auto_mask    (auto_mask),
    .en_set       (en_set),
    .dmarq        (dmarq),
    .irq_en       (irq_en),
    .irq_pend     (irq_pend),
    .burst_active (burst_active)
);

// File: tb/pktirq_dma_ctrl_test.sv
`timescale 1ns/1ps
module pktirq_dma_ctrl_test;
    localparam int CNT_W = 6;
    localparam int LINE_W = 9;
    localparam int PB = 44;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [CNT_W-1:0] pkt_avail = '0;
    logic [LINE_W-1:0] line_num = '0;
    logic rd_strobe = 1'b0, dmack = 1'b0;
    logic [CNT_W-1:0] thr_level = '0;
    logic line_gate_en = 1'b0;
    logic [LINE_W-1:0] line_target = '0;
    logic [1:0] auto_mask = '0, en_set = '0, en_clr = '0, sts_clr = '0, dma_mode = '0;
    logic [CNT_W-1:0] burst_len = '0;
    logic dma_start = 1'b0;
    logic irq, dmarq, burst_active;
    logic [1:0] irq_en, irq_pend;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    pktirq_dma_ctrl uut (
        .clk(clk), .rst(rst), .pkt_avail(pkt_avail), .line_num(line_num),
        .rd_strobe(rd_strobe), .dmack(dmack), .thr_level(thr_level),
        .line_gate_en(line_gate_en), .line_target(line_target),
        .auto_mask(auto_mask), .en_set(en_set), .en_clr(en_clr), .sts_clr(sts_clr),
        .dma_mode(dma_mode), .burst_len(burst_len), .dma_start(dma_start),
        .irq(irq), .dmarq(dmarq), .irq_en(irq_en), .irq_pend(irq_pend),
        .burst_active(burst_active)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic pulse_ctl(input logic [1:0] s, input logic [1:0] c, input logic [1:0] k);
        en_set = s; en_clr = c; sts_clr = k;
        step();
        en_set = '0; en_clr = '0; sts_clr = '0;
    endtask

    // One byte handshake; R9 checks on drop and on re-request.
    task automatic move_byte(input bit last_of_buf, input bit expect_more);
        int w = 0;
        while (!dmarq && w < 20) begin step(); w++; end
        check("R9 request before ack", int'(dmarq), 1);
        dmack = 1'b1; rd_strobe = 1'b1;
        step();
        check("R9 request dropped after ack", int'(dmarq), 0);
        dmack = 1'b0; rd_strobe = 1'b0;
        if (last_of_buf) pkt_avail = pkt_avail - 1'b1;
        step();
        if (expect_more) check("R9 request returns", int'(dmarq), 1);
    endtask

    initial begin
        #(5.0 * 150000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst = 1'b0;
        step();
        // R1
        check("R1 irq", int'(irq), 0);
        check("R1 dmarq", int'(dmarq), 0);
        check("R1 pend", int'(irq_pend), 0);
        check("R1 en", int'(irq_en), 0);
        check("R1 burst_active", int'(burst_active), 0);

        // R2 / R7: threshold sweep, bit0 is the count source
        for (int thr = 1; thr <= 7; thr++) begin
            thr_level = CNT_W'(thr);
            pkt_avail = '0;
            pulse_ctl(2'b01, 2'b00, 2'b11);
            for (int a = 1; a <= 8; a++) begin
                pkt_avail = CNT_W'(a);
                step();
                check("R2 count pend", int'(irq_pend[0]), (a >= thr) ? 1 : 0);
                check("R7 irq follows pend", int'(irq), (a >= thr) ? 1 : 0);
            end
        end
        check("R5 enable kept without auto mask", int'(irq_en[0]), 1);

        // R13: zero threshold never fires
        thr_level = '0; pkt_avail = '0;
        pulse_ctl(2'b00, 2'b00, 2'b11);
        for (int a = 0; a <= 10; a++) begin
            pkt_avail = CNT_W'(a);
            step();
            check("R13 zero threshold", int'(irq_pend[0]), 0);
        end

        // R4: disabled source ignores event
        thr_level = 6'd3; pkt_avail = '0;
        pulse_ctl(2'b00, 2'b01, 2'b11);
        pkt_avail = 6'd5; step();
        check("R4 disabled pend", int'(irq_pend[0]), 0);
        check("R4 disabled en", int'(irq_en[0]), 0);
        check("R4 irq low", int'(irq), 0);

        // R5: self masking
        pkt_avail = '0; auto_mask = 2'b01;
        pulse_ctl(2'b01, 2'b00, 2'b00);
        pkt_avail = 6'd4; step();
        check("R5 fired", int'(irq_pend[0]), 1);
        check("R5 enable cleared", int'(irq_en[0]), 0);
        auto_mask = 2'b00;

        // R6: clear alone, then clear with simultaneous event
        pulse_ctl(2'b00, 2'b00, 2'b01);
        check("R6 cleared", int'(irq_pend[0]), 0);
        pkt_avail = '0;
        pulse_ctl(2'b01, 2'b00, 2'b00);
        pkt_avail = 6'd4; sts_clr = 2'b01;
        step();
        sts_clr = '0;
        check("R6 event beats clear", int'(irq_pend[0]), 1);
        pulse_ctl(2'b00, 2'b00, 2'b01);
        check("R6 later clear", int'(irq_pend[0]), 0);

        // R3: line gating sweep
        line_gate_en = 1'b1; line_target = 9'd20; line_num = '0;
        thr_level = 6'd2; pkt_avail = 6'd3;
        step();
        pulse_ctl(2'b00, 2'b00, 2'b01);
        for (int ln = 0; ln <= 30; ln++) begin
            line_num = LINE_W'(ln);
            step();
            check("R3 gated pend", int'(irq_pend[0]), (ln >= 20) ? 1 : 0);
        end
        line_gate_en = 1'b0; thr_level = '0;
        pulse_ctl(2'b00, 2'b01, 2'b01);

        // R8: off encodings keep the request low
        pkt_avail = 6'd2;
        dma_mode = 2'd0; repeat (3) step();
        check("R8 mode 0 quiet", int'(dmarq), 0);
        dma_mode = 2'd3; repeat (3) step();
        check("R8 mode 3 quiet", int'(dmarq), 0);

        // R10: demand mode drains two packets then stops
        dma_mode = 2'd2;
        for (int p = 0; p < 2; p++)
            for (int b = 0; b < PB; b++)
                move_byte(b == PB - 1, !(p == 1 && b == PB - 1));
        repeat (3) step();
        check("R10 demand idle when empty", int'(dmarq), 0);
        pkt_avail = 6'd1; repeat (2) step();
        check("R10 demand re-requests", int'(dmarq), 1);
        dma_mode = 2'd0; pkt_avail = '0; step();

        // R11 / R12: burst runs of 1..3 packets, one surplus packet waiting
        for (int len = 1; len <= 3; len++) begin
            auto_mask = (len == 2) ? 2'b10 : 2'b00;
            pulse_ctl(2'b10, 2'b00, 2'b10);
            pkt_avail = CNT_W'(len + 1);
            burst_len = CNT_W'(len);
            dma_mode = 2'd1; dma_start = 1'b1;
            step();
            dma_start = 1'b0;
            check("R11 burst active", int'(burst_active), 1);
            for (int p = 0; p < len; p++)
                for (int b = 0; b < PB; b++) begin
                    if (p == len - 1 && b == PB - 1) begin
                        check("R11 active before last byte", int'(burst_active), 1);
                        move_byte(1'b1, 1'b0);
                    end else begin
                        move_byte(b == PB - 1, 1'b1);
                    end
                end
            check("R11 burst ended", int'(burst_active), 0);
            repeat (3) step();
            check("R11 no request after burst", int'(dmarq), 0);
            check("R12 done pending", int'(irq_pend[1]), 1);
            check("R12 done enable", int'(irq_en[1]), (len == 2) ? 0 : 1);
            check("R7 irq from done", int'(irq), 1);
            dma_mode = 2'd0; step();
        end

        // R4 for the done source
        pulse_ctl(2'b00, 2'b10, 2'b10);
        pkt_avail = 6'd2; burst_len = 6'd1; dma_mode = 2'd1; dma_start = 1'b1;
        step(); dma_start = 1'b0;
        for (int b = 0; b < PB; b++) move_byte(b == PB - 1, b != PB - 1);
        step();
        check("R12 disabled done ignored", int'(irq_pend[1]), 0);
        check("R11 ended", int'(burst_active), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule